// File: doc/BRIEF.md
# VLIW Multiway Branch Sequencer

This block is the program-counter sequencer of a small VLIW processing element. Each cycle it decodes one branch instruction. The instruction carries an opcode, one select field for each of n branch flags, and 2^n target addresses. Each select field picks a single bit from a pool of condition sources: control-register bits, input control signals, or one of the four status flags of any add/subtract unit. The n picked bits form an index into the target list, and the chosen target becomes the next program counter. A single instruction can therefore resolve a 2^n-way decision in one cycle.

A second opcode steps the program counter by one. The counter wraps at the instruction memory depth, which need not be a power of two. Both the program counter and the index that produced it are registered outputs, so they change on the same clock edge.

Top module: `mwb_sequencer`

## Requirements
- R1: While rst_ni is low, pc_o and idx_o are 0. The reset acts without waiting for a clock edge.
- R2: The opcode is instr_i[1:0], and 2'b00 means step. On each rising edge with a step opcode, pc_o becomes pc_o+1 and idx_o becomes 0.
- R3: A step from pc_o = IMEM_DEPTH-1 (47 by default) gives pc_o = 0.
- R4: Opcodes 2'b10 and 2'b11 behave exactly as the step opcode.
- R5: Opcode 2'b01 means branch. On the rising edge, pc_o loads target t, which lies at instr_i[12 + t*6 +: 6] with the defaults.
- R6: On a branch, bit k of the index t is the flag picked by select field k, so flag 0 is the least significant bit. idx_o shows t after the same edge that loads pc_o.
- R7: Select field k lies at instr_i[2 + k*5 +: 5]. Within the field, bits [1:0] give the source (0 control register, 1 control input, 2 status, 3 constant zero), bits [3:2] give the bit or status kind, and bit [4] gives the add/subtract unit.
- R8: Source 0 picks ctrl_reg_i[bit], and source 1 picks ctrl_in_i[bit].
- R9: Source 2 picks status_i[4*unit + kind]. The kinds are 0 carry, 1 overflow, 2 negative and 3 zero.
- R10: Source 3 yields a 0 flag, whatever the pool holds.
- R11: On a step, the flag pool, the select fields and the target fields have no effect on pc_o or idx_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 36 | Branch instruction word: opcode, select fields, targets |
| ctrl_reg_i | input | 4 | Control-register bits |
| ctrl_in_i | input | 4 | Input control signals |
| status_i | input | 8 | Status flags, four per add/subtract unit |
| pc_o | output | 6 | Program counter |
| idx_o | output | 2 | Target index used for the current pc_o |

## Verification
The assertions check three behaviours on every cycle:
- Any non-branch opcode steps the counter with wrap and clears the index.
- After a branch, pc_o equals the target field that idx_o addresses in the previous instruction.
- A flag whose source is constant zero never sets its index bit.

The assertions cannot see whether the right pool bit was picked for each source, unit and kind. Only the bench's scenarios show that, by comparing pc_o and idx_o against hand-derived values for chosen pools. The bench also covers the reset in mid-run and a full lap of the counter around the wrap point.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

  localparam int OPC_W      = 2;
  localparam int SRC_W      = 2;
  localparam int STAT_KINDS = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_STEP   = 2'b00,
    OPC_BRANCH = 2'b01
  } opc_e;

  typedef enum logic [SRC_W-1:0] {
    SRC_CREG = 2'd0,
    SRC_CIN  = 2'd1,
    SRC_STAT = 2'd2,
    SRC_ZERO = 2'd3
  } src_e;

  // status kind order inside one unit's group
  typedef enum logic [1:0] {
    STAT_CARRY = 2'd0,
    STAT_OVF   = 2'd1,
    STAT_NEG   = 2'd2,
    STAT_ZERO  = 2'd3
  } stat_kind_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/mwb_flag_pick.sv
module mwb_flag_pick
  import mwb_pkg::*;
#(
  parameter int N_CREG = 4,
  parameter int N_CIN  = 4,
  parameter int N_ADD  = 2,
  parameter int BIT_W  = 2,
  parameter int UNIT_W = 1,
  localparam int SEL_W = SRC_W + BIT_W + UNIT_W
) (
  input  logic [SEL_W-1:0]            sel_i,
  input  logic [N_CREG-1:0]           ctrl_reg_i,
  input  logic [N_CIN-1:0]            ctrl_in_i,
  input  logic [STAT_KINDS*N_ADD-1:0] status_i,
  output logic                        flag_o
);

  logic [SRC_W-1:0]      src;
  logic [BIT_W-1:0]      bsel;
  logic [UNIT_W-1:0]     usel;
  logic                  creg_bit, cin_bit, stat_bit;
  logic [STAT_KINDS-1:0] unit_grp;

  assign src  = sel_i[SRC_W-1:0];
  assign bsel = sel_i[SRC_W +: BIT_W];
  assign usel = sel_i[SRC_W+BIT_W +: UNIT_W];

  always_comb begin
    creg_bit = 1'b0;
    for (int i = 0; i < N_CREG; i++)
      if (bsel == BIT_W'(i)) creg_bit = ctrl_reg_i[i];
  end

  always_comb begin
    cin_bit = 1'b0;
    for (int i = 0; i < N_CIN; i++)
      if (bsel == BIT_W'(i)) cin_bit = ctrl_in_i[i];
  end

  // first level: unit; second level: kind
  always_comb begin
    unit_grp = '0;
    for (int u = 0; u < N_ADD; u++)
      if (usel == UNIT_W'(u)) unit_grp = status_i[STAT_KINDS*u +: STAT_KINDS];
  end

  always_comb begin
    stat_bit = 1'b0;
    for (int k = 0; k < STAT_KINDS; k++)
      if (bsel[1:0] == 2'(k)) stat_bit = unit_grp[k];
  end

  always_comb begin
    unique case (src)
      SRC_CREG: flag_o = creg_bit;
      SRC_CIN:  flag_o = cin_bit;
      SRC_STAT: flag_o = stat_bit;
      default:  flag_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/mwb_target_pick.sv
module mwb_target_pick #(
  parameter int N_FLAGS = 2,
  parameter int PC_W    = 6,
  localparam int N_TGT  = 1 << N_FLAGS
) (
  input  logic [N_TGT*PC_W-1:0] tgts_i,
  input  logic [N_FLAGS-1:0]    idx_i,
  output logic [PC_W-1:0]       tgt_o
);

  always_comb begin
    tgt_o = '0;
    for (int t = 0; t < N_TGT; t++)
      if (idx_i == N_FLAGS'(t)) tgt_o = tgts_i[t*PC_W +: PC_W];
  end

endmodule

// File: rtl/mwb_pc_next.sv
module mwb_pc_next
  import mwb_pkg::*;
#(
  parameter int IMEM_DEPTH = 48,
  parameter int N_FLAGS    = 2,
  parameter int PC_W       = 6
) (
  input  logic [OPC_W-1:0]   opc_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [PC_W-1:0]    tgt_i,
  input  logic [N_FLAGS-1:0] idx_i,
  output logic [PC_W-1:0]    pc_nxt_o,
  output logic [N_FLAGS-1:0] idx_nxt_o
);

  localparam logic [PC_W-1:0] PC_LAST = PC_W'(IMEM_DEPTH - 1);

  logic [PC_W-1:0] pc_inc;

  assign pc_inc = (pc_i == PC_LAST) ? '0 : pc_i + PC_W'(1);

  // unknown opcodes fall back to step
  always_comb begin
    if (opc_i == OPC_BRANCH) begin
      pc_nxt_o  = tgt_i;
      idx_nxt_o = idx_i;
    end else begin
      pc_nxt_o  = pc_inc;
      idx_nxt_o = '0;
    end
  end

endmodule

// File: rtl/mwb_sequencer.sv
module mwb_sequencer
  import mwb_pkg::*;
#(
  parameter int IMEM_DEPTH = 48,
  parameter int N_FLAGS    = 2,
  parameter int N_CREG     = 4,
  parameter int N_CIN      = 4,
  parameter int N_ADD      = 2,
  localparam int PC_W      = (IMEM_DEPTH > 1) ? $clog2(IMEM_DEPTH) : 1,
  localparam int BIT_W     = $clog2(max3(N_CREG, N_CIN, STAT_KINDS)),
  localparam int UNIT_W    = (N_ADD > 1) ? $clog2(N_ADD) : 1,
  localparam int SEL_W     = SRC_W + BIT_W + UNIT_W,
  localparam int N_TGT     = 1 << N_FLAGS,
  localparam int TGT_OFF   = OPC_W + N_FLAGS * SEL_W,
  localparam int INSTR_W   = TGT_OFF + N_TGT * PC_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [INSTR_W-1:0]          instr_i,
  input  logic [N_CREG-1:0]           ctrl_reg_i,
  input  logic [N_CIN-1:0]            ctrl_in_i,
  input  logic [STAT_KINDS*N_ADD-1:0] status_i,
  output logic [PC_W-1:0]             pc_o,
  output logic [N_FLAGS-1:0]          idx_o
);

  logic [N_FLAGS-1:0] idx;
  logic [PC_W-1:0]    tgt;
  logic [PC_W-1:0]    pc_nxt, pc_q;
  logic [N_FLAGS-1:0] idx_nxt, idx_q;

  for (genvar k = 0; k < N_FLAGS; k++) begin : g_flag
    mwb_flag_pick #(
      .N_CREG(N_CREG), .N_CIN(N_CIN), .N_ADD(N_ADD),
      .BIT_W(BIT_W), .UNIT_W(UNIT_W)
    ) u_pick (
      .sel_i      (instr_i[OPC_W + k*SEL_W +: SEL_W]),
      .ctrl_reg_i (ctrl_reg_i),
      .ctrl_in_i  (ctrl_in_i),
      .status_i   (status_i),
      .flag_o     (idx[k])
    );
  end

  mwb_target_pick #(.N_FLAGS(N_FLAGS), .PC_W(PC_W)) u_tgt (
    .tgts_i (instr_i[TGT_OFF +: N_TGT*PC_W]),
    .idx_i  (idx),
    .tgt_o  (tgt)
  );

  mwb_pc_next #(.IMEM_DEPTH(IMEM_DEPTH), .N_FLAGS(N_FLAGS), .PC_W(PC_W)) u_next (
    .opc_i     (instr_i[OPC_W-1:0]),
    .pc_i      (pc_q),
    .tgt_i     (tgt),
    .idx_i     (idx),
    .pc_nxt_o  (pc_nxt),
    .idx_nxt_o (idx_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      idx_q <= '0;
    end else begin
      pc_q  <= pc_nxt;
      idx_q <= idx_nxt;
    end
  end

  assign pc_o  = pc_q;
  assign idx_o = idx_q;

endmodule

// File: rtl/mwb_sequencer_chk.sv
module mwb_sequencer_chk
  import mwb_pkg::*;
#(
  parameter int IMEM_DEPTH = 48,
  parameter int N_FLAGS    = 2,
  parameter int PC_W       = 6,
  parameter int SEL_W      = 5,
  parameter int TGT_OFF    = 12,
  parameter int INSTR_W    = 36
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [INSTR_W-1:0] instr_i,
  input logic [PC_W-1:0]    pc_o,
  input logic [N_FLAGS-1:0] idx_o
);

  localparam logic [PC_W-1:0] PC_LAST = PC_W'(IMEM_DEPTH - 1);

  logic               is_branch;
  logic               prev_branch;
  logic [INSTR_W-1:0] prev_instr;

  assign is_branch = (instr_i[OPC_W-1:0] == OPC_BRANCH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_branch <= 1'b0;
      prev_instr  <= '0;
    end else begin
      prev_branch <= is_branch;
      prev_instr  <= instr_i;
    end
  end

  // R1
  always @(posedge clk_i)
    if (!rst_ni) a_r1_reset_clears: assert (pc_o == '0 && idx_o == '0)
      else $error("a_r1_reset_clears");

  // R2 R3 R4
  a_r2_step_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_branch |=> pc_o == (($past(pc_o) == PC_LAST) ? '0 : $past(pc_o) + PC_W'(1)))
    else $error("a_r2_step_wraps");

  // R11
  a_r11_step_idx_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_branch |=> idx_o == '0)
    else $error("a_r11_step_idx_zero");

  // R5 R6
  a_r5_branch_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prev_branch |-> pc_o == prev_instr[TGT_OFF + int'(idx_o)*PC_W +: PC_W])
    else $error("a_r5_branch_target");

  // R10
  for (genvar k = 0; k < N_FLAGS; k++) begin : g_zero
    a_r10_zero_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_branch && instr_i[OPC_W + k*SEL_W +: SRC_W] == SRC_ZERO) |=> !idx_o[k])
      else $error("a_r10_zero_src");
  end

endmodule

bind mwb_sequencer mwb_sequencer_chk #(
  .IMEM_DEPTH (IMEM_DEPTH),
  .N_FLAGS    (N_FLAGS),
  .PC_W       (PC_W),
  .SEL_W      (SEL_W),
  .TGT_OFF    (TGT_OFF),
  .INSTR_W    (INSTR_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .instr_i (instr_i),
  .pc_o    (pc_o),
  .idx_o   (idx_o)
);

// File: tb/mwb_sequencer_tb_top.sv
`timescale 1ns/1ps
module mwb_sequencer_tb_top;

  localparam int CLK_PER = 8;
  localparam int DEPTH   = 48;
  localparam int NVEC    = 12;
  // targets 0..3 placed at bit 12 + t*6 (R5)
  localparam logic [5:0] T0 = 6'd5, T1 = 6'd17, T2 = 6'd33, T3 = 6'd46;

  typedef struct packed {
    logic [1:0] op;
    logic [4:0] sel0;   // {unit, bit[1:0], src[1:0]} (R7)
    logic [4:0] sel1;
    logic [3:0] creg;
    logic [3:0] cin;
    logic [7:0] stat;
    logic [5:0] exp_pc;
    logic [1:0] exp_idx;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 5'b0_00_00, 5'b0_00_00, 4'b1111, 4'b0000, 8'h00, 6'd1,  2'd0}, // R2 R11
    '{2'd1, 5'b0_10_00, 5'b0_01_01, 4'b0100, 4'b0000, 8'h00, 6'd17, 2'd1}, // R5 R6 R8
    '{2'd1, 5'b1_11_10, 5'b0_00_10, 4'b0000, 4'b0000, 8'h81, 6'd46, 2'd3}, // R9 zero u1, carry u0
    '{2'd0, 5'b0_00_00, 5'b0_00_00, 4'b0000, 4'b0000, 8'h00, 6'd47, 2'd0}, // R2
    '{2'd0, 5'b0_00_00, 5'b0_00_00, 4'b0000, 4'b0000, 8'h00, 6'd0,  2'd0}, // R3
    '{2'd2, 5'b0_00_00, 5'b0_00_00, 4'b1111, 4'b0000, 8'h00, 6'd1,  2'd0}, // R4
    '{2'd3, 5'b0_00_00, 5'b0_00_00, 4'b1111, 4'b0000, 8'h00, 6'd2,  2'd0}, // R4
    '{2'd1, 5'b0_00_11, 5'b0_11_01, 4'b1111, 4'b1000, 8'h00, 6'd33, 2'd2}, // R10 R8
    '{2'd1, 5'b0_01_10, 5'b1_10_10, 4'b0000, 4'b0000, 8'h02, 6'd17, 2'd1}, // R9 ovf u0, neg u1
    '{2'd1, 5'b0_00_11, 5'b0_00_11, 4'b1111, 4'b1111, 8'hff, 6'd5,  2'd0}, // R10
    '{2'd1, 5'b0_00_01, 5'b0_11_00, 4'b1000, 4'b0001, 8'h00, 6'd46, 2'd3}, // R8 R6
    '{2'd0, 5'b0_00_00, 5'b0_00_00, 4'b0000, 4'b0000, 8'h00, 6'd47, 2'd0}  // R2
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic [35:0] instr_i = '0;
  logic [3:0]  ctrl_reg_i = '0;
  logic [3:0]  ctrl_in_i = '0;
  logic [7:0]  status_i = '0;
  logic [5:0]  pc_o;
  logic [1:0]  idx_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PER/2) clk_i = ~clk_i;

  mwb_sequencer dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .instr_i    (instr_i),
    .ctrl_reg_i (ctrl_reg_i),
    .ctrl_in_i  (ctrl_in_i),
    .status_i   (status_i),
    .pc_o       (pc_o),
    .idx_o      (idx_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [35:0] mk_instr(input logic [1:0] op, input logic [4:0] s0,
                                            input logic [4:0] s1);
    logic [35:0] w;
    w = '0;
    w[1:0]   = op;
    w[2 +: 5] = s0;
    w[7 +: 5] = s1;
    w[12 +: 6] = T0;
    w[18 +: 6] = T1;
    w[24 +: 6] = T2;
    w[30 +: 6] = T3;
    return w;
  endfunction

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1 reset pc", 8'(pc_o), 8'd0);
    chk("R1 reset idx", 8'(idx_o), 8'd0);
    rst_ni = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      instr_i    = mk_instr(VECS[v].op, VECS[v].sel0, VECS[v].sel1);
      ctrl_reg_i = VECS[v].creg;
      ctrl_in_i  = VECS[v].cin;
      status_i   = VECS[v].stat;
      @(posedge clk_i);
      @(negedge clk_i);
      chk($sformatf("vector %0d pc (R2 R3 R4 R5 R6 R7 R8 R9 R10 R11)", v),
          8'(pc_o), 8'(VECS[v].exp_pc));
      chk($sformatf("vector %0d idx (R6 R7 R8 R9 R10 R11)", v),
          8'(idx_o), 8'(VECS[v].exp_idx));
    end

    // R1: reset in mid-run clears without a clock edge
    #1 rst_ni = 1'b0;
    #1;
    chk("R1 async reset pc", 8'(pc_o), 8'd0);
    chk("R1 async reset idx", 8'(idx_o), 8'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R3: full lap of steps, wrap back to 0; R11 flags and targets ignored
    instr_i    = mk_instr(2'd0, 5'b0_00_00, 5'b0_00_10);
    ctrl_reg_i = 4'b1111;
    status_i   = 8'hff;
    for (int k = 1; k <= DEPTH; k++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      chk($sformatf("R3 lap step %0d pc", k), 8'(pc_o), 8'(k % DEPTH));
    end
    chk("R11 lap idx", 8'(idx_o), 8'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule